// File: doc/BRIEF.md
# Four-Channel Block Transfer Sequencer

The sequencer moves blocks of 16-bit or 32-bit units from a source address to a destination address for four independent channels. Each channel's addresses, unit count and control fields come from an external register block. A channel is armed by one of four start conditions: software enable, a horizontal-blank pulse, a vertical-blank pulse, or a channel-specific special trigger. Once armed, the channel waits a fixed start latency and then competes for the single transfer engine.

The engine serves one unit at a time. Each unit is a read from the working source address, held in a shared 32-bit latch, followed by a write of that latch to the working destination. The engine then idles for the unit's wait-state cost and steps both addresses. Costs come from four wait-state tables indexed by the top four address bits (the region), supplied as inputs. At the end of a burst the block pulses the channel's interrupt line and, when the channel must not run again, a strobe that tells the register block to clear the enable. A stall output holds the CPU off the bus while work is pending.

Top module: `dma_sequencer`

## Requirements
- R1: After reset, `cpu_stall`, `mem_rd`, `mem_wr`, `irq` and `en_clr` are all low.
- R2: A channel in mode 0 (immediate) is armed when its enable rises. Its first read request appears 4 cycles after the cycle in which enable is first seen high, which is 3 cycles of latency after the sampling edge.
- R3: In mode 1, a `hblank` pulse arms an enabled channel that has no burst pending. Mode 2 does the same with `vblank`. A pulse of the other kind, or one that arrives while the burst is pending, has no effect. Arming reloads the pending count.
- R4: In mode 3, channel 3 is armed by `disp_start`, channel 1 by `fifo_req[0]` and channel 2 by `fifo_req[1]`. Channel 0 in mode 3 never transfers.
- R5: Each unit is one read cycle followed directly by one write cycle. The unit lasts 2 cycles plus the source-region and destination-region wait states. The first unit after arming takes these from the nonsequential table and later units from the sequential table, each chosen by width (`ch_wide`=1 means 32-bit).
- R6: The address control is 2 bits per side: 0 increment, 1 decrement, 2 fixed, 3 increment. The step is 2 bytes for 16-bit units and 4 bytes for 32-bit units.
- R7: A 16-bit read places `mem_rdata[15:0]` in both halves of `mem_wdata`. With a working source of 0 no read is issued, the previous latch value is written, and the source does not move.
- R8: When the count runs out, `irq[ch]` pulses for one cycle if `ch_irq_en[ch]` is set. `en_clr[ch]` pulses if repeat is off, if the mode is 0, or if the channel is channel 3 in mode 3 with `last_line` high. Otherwise the channel stays enabled.
- R9: The last unit of a burst costs 2 extra cycles when the source or destination region is below 8.
- R10: `cpu_stall` is high in every cycle in which a unit is in progress or a channel is due, and low otherwise. Any memory request occurs with `cpu_stall` high.
- R11: Among due channels, the lowest-numbered one wins at each unit boundary. A channel that becomes due during another channel's burst is served after the current unit, before that burst resumes.
- R12: A programmed count of 0 means 2^CW units.
- R13: On the rising edge of enable, the working addresses are loaded from the programmed ones with the low bits cleared to the unit width. In mode 3 on the destination side, the destination returns to this aligned programmed address when the burst ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 4 | Per-channel enable from the register block |
| ch_mode | input | 8 | 2-bit start mode per channel (0 immediate, 1 hblank, 2 vblank, 3 special) |
| ch_wide | input | 4 | Per-channel unit width, 1 = 32-bit |
| ch_sctl | input | 8 | 2-bit source address control per channel |
| ch_dctl | input | 8 | 2-bit destination address control per channel |
| ch_rpt | input | 4 | Per-channel repeat |
| ch_irq_en | input | 4 | Per-channel interrupt enable |
| ch_src | input | 4*AW | Programmed source addresses |
| ch_dst | input | 4*AW | Programmed destination addresses |
| ch_cnt | input | 4*CW | Programmed unit counts |
| hblank | input | 1 | Horizontal-blank pulse |
| vblank | input | 1 | Vertical-blank pulse |
| disp_start | input | 1 | Display-start pulse (channel 3 special) |
| fifo_req | input | 2 | Audio FIFO requests (channels 1 and 2 special) |
| last_line | input | 1 | High on the scanline just after the visible area |
| ws_n16 | input | 16*WSW | Nonsequential 16-bit wait states per region |
| ws_s16 | input | 16*WSW | Sequential 16-bit wait states per region |
| ws_n32 | input | 16*WSW | Nonsequential 32-bit wait states per region |
| ws_s32 | input | 16*WSW | Sequential 32-bit wait states per region |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_addr | output | AW | Request address |
| mem_wide | output | 1 | Request is 32-bit |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the cycle of `mem_rd` |
| cpu_stall | output | 1 | CPU hold-off |
| irq | output | 4 | End-of-burst interrupt pulses |
| en_clr | output | 4 | Enable-clear strobes |

## Verification
The embedded assertions check, on every cycle, the invariants of the bus side. A read is always followed by a write, the two never coincide, every request falls under `cpu_stall`, and interrupt and enable-clear pulses are single-cycle and never name two channels at once. Other behaviour can only be shown by the bench's scenarios: start latency, wait-state totals with the nonsequential/sequential split and the extra end cycles, final addresses under each address-control mode, destination reload, latch replay for a zero source, the repeat rule per mode, and the order of writes under priority and preemption.

// File: rtl/dma_sequencer.sv
module dma_sequencer #(
  parameter int AW = 28,
  parameter int CW = 16,
  parameter int WSW = 4,
  parameter int CART_REG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        ch_en,
  input  logic [7:0]        ch_mode,
  input  logic [3:0]        ch_wide,
  input  logic [7:0]        ch_sctl,
  input  logic [7:0]        ch_dctl,
  input  logic [3:0]        ch_rpt,
  input  logic [3:0]        ch_irq_en,
  input  logic [4*AW-1:0]   ch_src,
  input  logic [4*AW-1:0]   ch_dst,
  input  logic [4*CW-1:0]   ch_cnt,
  input  logic              hblank,
  input  logic              vblank,
  input  logic              disp_start,
  input  logic [1:0]        fifo_req,
  input  logic              last_line,
  input  logic [16*WSW-1:0] ws_n16,
  input  logic [16*WSW-1:0] ws_s16,
  input  logic [16*WSW-1:0] ws_n32,
  input  logic [16*WSW-1:0] ws_s32,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_wide,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              cpu_stall,
  output logic [3:0]        irq,
  output logic [3:0]        en_clr
);
  localparam int CTW = WSW + 3;
  localparam logic [3:0] CREG = 4'(CART_REG);

  logic [3:0]    en_q, pend, first, due, arm;
  logic [1:0]    dly  [4];
  logic [CW:0]   left [4];
  logic [AW-1:0] nsrc [4];
  logic [AW-1:0] ndst [4];
  logic [31:0]   latch;
  logic          active, pick_v;
  logic [1:0]    act, pick;
  logic [CTW-1:0] ucyc, cost, cost_nx;

  function automatic logic [AW-1:0] align(input logic [AW-1:0] a, input logic w);
    return w ? {a[AW-1:2], 2'b00} : {a[AW-1:1], 1'b0};
  endfunction

  function automatic logic [AW-1:0] stepa(input logic [AW-1:0] a, input logic [1:0] c, input logic w);
    logic [AW-1:0] s;
    s = w ? AW'(4) : AW'(2);
    case (c)
      2'd1:    return a - s;
      2'd2:    return a;
      default: return a + s;
    endcase
  endfunction

  function automatic logic [CTW-1:0] wsel(input logic [16*WSW-1:0] t, input logic [3:0] r);
    return CTW'(t[r*WSW +: WSW]);
  endfunction

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      due[i] = pend[i] && dly[i] == 2'd0 && ch_en[i];
      case (ch_mode[2*i +: 2])
        2'd0: arm[i] = ch_en[i] && !en_q[i];
        2'd1: arm[i] = ch_en[i] && !pend[i] && hblank;
        2'd2: arm[i] = ch_en[i] && !pend[i] && vblank;
        default: arm[i] = ch_en[i] && !pend[i] &&
                          (i == 3 ? disp_start : i == 2 ? fifo_req[1] : i == 1 ? fifo_req[0] : 1'b0);
      endcase
    end
    pick_v = 1'b0;
    pick = 2'd0;
    for (int i = 3; i >= 0; i--)
      if (due[i]) begin
        pick_v = 1'b1;
        pick = 2'(i);
      end
  end

  logic [3:0] sreg, dreg;
  logic [16*WSW-1:0] tbl;
  assign sreg = nsrc[pick][AW-1 -: 4];
  assign dreg = ndst[pick][AW-1 -: 4];
  assign tbl = first[pick] ? (ch_wide[pick] ? ws_n32 : ws_n16) : (ch_wide[pick] ? ws_s32 : ws_s16);
  assign cost_nx = CTW'(2) + wsel(tbl, sreg) + wsel(tbl, dreg) +
                   ((left[pick] == (CW+1)'(1) && (sreg < CREG || dreg < CREG)) ? CTW'(2) : CTW'(0));

  assign mem_rd    = !active && pick_v && nsrc[pick] != '0;
  assign mem_wr    = active && ucyc == CTW'(1);
  assign mem_addr  = active ? ndst[act] : nsrc[pick];
  assign mem_wide  = active ? ch_wide[act] : ch_wide[pick];
  assign mem_wdata = latch;
  assign cpu_stall = active || (|due);

  logic no_rpt;
  assign no_rpt = !ch_rpt[act] || ch_mode[{act, 1'b0} +: 2] == 2'd0 ||
                  (act == 2'd3 && ch_mode[7:6] == 2'd3 && last_line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; pend <= '0; first <= '0; irq <= '0; en_clr <= '0;
      latch <= '0; active <= 1'b0; act <= '0; ucyc <= '0; cost <= '0;
      for (int i = 0; i < 4; i++) begin
        dly[i] <= '0; left[i] <= '0; nsrc[i] <= '0; ndst[i] <= '0;
      end
    end else begin
      en_q <= ch_en;
      irq <= '0;
      en_clr <= '0;
      for (int i = 0; i < 4; i++) begin
        if (!ch_en[i]) begin
          pend[i] <= 1'b0;
          dly[i] <= '0;
        end else if (!en_q[i]) begin
          nsrc[i] <= align(ch_src[i*AW +: AW], ch_wide[i]);
          ndst[i] <= align(ch_dst[i*AW +: AW], ch_wide[i]);
        end
        if (arm[i]) begin
          pend[i] <= 1'b1;
          dly[i] <= 2'd3;
          first[i] <= 1'b1;
          left[i] <= (ch_cnt[i*CW +: CW] == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, ch_cnt[i*CW +: CW]};
        end else if (dly[i] != 2'd0) begin
          dly[i] <= dly[i] - 2'd1;
        end
      end
      if (!active && pick_v) begin
        active <= 1'b1;
        act <= pick;
        ucyc <= CTW'(1);
        cost <= cost_nx;
        if (nsrc[pick] != '0)
          latch <= ch_wide[pick] ? mem_rdata : {mem_rdata[15:0], mem_rdata[15:0]};
      end else if (active) begin
        if (ucyc == cost - CTW'(1)) begin
          active <= 1'b0;
          first[act] <= 1'b0;
          left[act] <= left[act] - (CW+1)'(1);
          if (nsrc[act] != '0)
            nsrc[act] <= stepa(nsrc[act], ch_sctl[{act, 1'b0} +: 2], ch_wide[act]);
          ndst[act] <= stepa(ndst[act], ch_dctl[{act, 1'b0} +: 2], ch_wide[act]);
          if (left[act] == (CW+1)'(1)) begin
            pend[act] <= 1'b0;
            irq[act] <= ch_irq_en[act];
            en_clr[act] <= no_rpt;
            if (ch_dctl[{act, 1'b0} +: 2] == 2'd3)
              ndst[act] <= align(ch_dst[act*AW +: AW], ch_wide[act]);
          end
        end else begin
          ucyc <= ucyc + CTW'(1);
        end
      end
    end
  end

  assert_rd_then_wr_R5: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> mem_wr);
  assert_no_dual_access_R7: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  assert_access_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd || mem_wr) |-> cpu_stall);
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(irq) && $onehot0(en_clr));
  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n) (|irq) |=> !(|irq));
  assert_wr_stall_held_R10: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> $past(cpu_stall));
endmodule

// File: tb/test_dma_sequencer.sv
module test_dma_sequencer;
  localparam int AW = 28, CW = 6, WSW = 4;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [3:0] ch_en = 0, ch_wide = 0, ch_rpt = 0, ch_irq_en = 0;
  logic [7:0] ch_mode = 0, ch_sctl = 0, ch_dctl = 0;
  logic [4*AW-1:0] ch_src = 0, ch_dst = 0;
  logic [4*CW-1:0] ch_cnt = 0;
  logic hblank = 0, vblank = 0, disp_start = 0, last_line = 0;
  logic [1:0] fifo_req = 0;
  logic [16*WSW-1:0] ws_n16 = {16{4'd3}}, ws_s16 = {16{4'd1}}, ws_n32 = {16{4'd5}}, ws_s32 = {16{4'd2}};
  logic mem_rd, mem_wr, mem_wide, cpu_stall;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0] irq, en_clr;

  function automatic logic [31:0] fmem(input logic [AW-1:0] a);
    return {a[15:0] ^ 16'h3C3C, a[15:0] ^ 16'hA5A5};
  endfunction
  assign mem_rdata = fmem(mem_addr);

  dma_sequencer #(.AW(AW), .CW(CW), .WSW(WSW)) i_dma_sequencer (
    .clk, .rst_n, .ch_en, .ch_mode, .ch_wide, .ch_sctl, .ch_dctl, .ch_rpt, .ch_irq_en,
    .ch_src, .ch_dst, .ch_cnt, .hblank, .vblank, .disp_start, .fifo_req, .last_line,
    .ws_n16, .ws_s16, .ws_n32, .ws_s32, .mem_rd, .mem_wr, .mem_addr, .mem_wide,
    .mem_wdata, .mem_rdata, .cpu_stall, .irq, .en_clr);

  int checks = 0, errors = 0, cyc = 0;
  int stall_n, nrd, nwr, first_rd, en_cyc;
  logic [AW-1:0] last_raddr, last_waddr;
  logic [AW-1:0] wlog [32];
  logic [31:0] last_wdata;
  logic [3:0] irq_seen, clr_seen;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    stall_n = 0; nrd = 0; nwr = 0; first_rd = -1;
    last_raddr = 0; last_waddr = 0; irq_seen = 0; clr_seen = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cpu_stall) stall_n++;
      if (mem_rd) begin
        nrd++; last_raddr = mem_addr;
        if (first_rd < 0) first_rd = cyc;
      end
      if (mem_wr) begin
        if (nwr < 32) wlog[nwr] = mem_addr;
        nwr++; last_waddr = mem_addr; last_wdata = mem_wdata;
      end
      irq_seen |= irq;
      clr_seen |= en_clr;
    end
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg(input int c, input logic [1:0] m, input logic w, input logic [1:0] sc,
                     input logic [1:0] dc, input logic r, input logic ie,
                     input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [CW-1:0] n);
    ch_mode[2*c +: 2] = m; ch_wide[c] = w; ch_sctl[2*c +: 2] = sc; ch_dctl[2*c +: 2] = dc;
    ch_rpt[c] = r; ch_irq_en[c] = ie; ch_src[c*AW +: AW] = s; ch_dst[c*AW +: AW] = d;
    ch_cnt[c*CW +: CW] = n;
  endtask

  task automatic enable(input int c);
    ch_en[c] = 1'b1;
    en_cyc = cyc + 1;
  endtask

  typedef struct packed {
    logic w; logic [1:0] sc; logic [1:0] dc;
    logic [27:0] src; logic [27:0] dst; logic [5:0] cnt;
    logic [31:0] cycles; logic [27:0] lw; logic [27:0] lr;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{1'b0, 2'd0, 2'd0, 28'h2000100, 28'h3000200, 6'd4, 32'd22, 28'h3000206, 28'h2000106},
    '{1'b1, 2'd1, 2'd2, 28'h2000400, 28'h3000010, 6'd3, 32'd26, 28'h3000010, 28'h20003F8},
    '{1'b1, 2'd2, 2'd1, 28'h8000000, 28'hE000100, 6'd2, 32'd18, 28'hE0000FC, 28'h8000000},
    '{1'b0, 2'd0, 2'd3, 28'h2000003, 28'h3000021, 6'd3, 32'd18, 28'h3000024, 28'h2000006}
  };

  initial begin
    logic [31:0] exp_d, saved;
    int idx;
    clear_log();
    tick(3);
    // R1 reset state
    chk("R1 stall", {31'd0, cpu_stall}, 0);
    chk("R1 mem", {30'd0, mem_rd, mem_wr}, 0);
    chk("R1 irq", {24'd0, irq, en_clr}, 0);
    rst_n = 1;
    tick(2);

    foreach (VEC[k]) begin
      clear_log();
      cfg(0, 2'd0, VEC[k].w, VEC[k].sc, VEC[k].dc, 1'b1, 1'b1, VEC[k].src, VEC[k].dst, VEC[k].cnt);
      enable(0);
      tick(60);
      exp_d = VEC[k].w ? fmem(VEC[k].lr) : {2{fmem(VEC[k].lr)[15:0]}};
      chk("R2 start latency", first_rd - en_cyc, 4);
      chk("R5 R9 cycle total", stall_n, VEC[k].cycles);
      chk("R5 unit count", nwr, {26'd0, VEC[k].cnt});
      chk("R6 R13 last write addr", {4'd0, last_waddr}, {4'd0, VEC[k].lw});
      chk("R6 last read addr", {4'd0, last_raddr}, {4'd0, VEC[k].lr});
      chk("R7 write data", last_wdata, exp_d);
      chk("R8 irq and clear in mode 0", {28'd0, irq_seen[0], clr_seen[0], 2'd0}, 32'hC);
      ch_en[0] = 0;
      tick(2);
    end

    // R7 zero source replays latch
    saved = last_wdata;
    clear_log();
    cfg(0, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 28'h0, 28'h3000080, 6'd2);
    enable(0);
    tick(40);
    chk("R7 no read on zero source", nrd, 0);
    chk("R7 writes on zero source", nwr, 2);
    chk("R7 replayed latch", last_wdata, saved);
    ch_en[0] = 0; tick(2);

    // R12 zero count
    clear_log();
    cfg(0, 2'd0, 1'b0, 2'd2, 2'd2, 1'b0, 1'b0, 28'h2000000, 28'h3000000, 6'd0);
    enable(0);
    tick(300);
    chk("R12 zero count units", nwr, 64);
    ch_en[0] = 0; tick(2);

    // R3 hblank mode, wrong pulse and pending pulse ignored, R13 reload
    clear_log();
    cfg(1, 2'd1, 1'b0, 2'd0, 2'd3, 1'b1, 1'b1, 28'h2000000, 28'h3000040, 6'd2);
    enable(1);
    tick(6);
    vblank = 1; tick(1); vblank = 0;
    tick(20);
    chk("R3 no transfer without own trigger", nwr, 0);
    hblank = 1; tick(1); hblank = 0;
    tick(2);
    hblank = 1; tick(1); hblank = 0;
    tick(40);
    chk("R3 pending pulse ignored", nwr, 2);
    chk("R8 repeat irq no clear", {30'd0, irq_seen[1], clr_seen[1]}, 2);
    clear_log();
    hblank = 1; tick(1); hblank = 0;
    tick(40);
    chk("R3 rearm after burst", nwr, 2);
    chk("R13 destination reload", {4'd0, wlog[0]}, 32'h3000040);
    ch_en[1] = 0; tick(2);

    // R4 special on channel 0 ignored
    clear_log();
    cfg(0, 2'd3, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 28'h2000000, 28'h3000000, 6'd1);
    enable(0);
    tick(2);
    disp_start = 1; fifo_req = 2'b11; tick(1); disp_start = 0; fifo_req = 0;
    tick(30);
    chk("R4 channel 0 special ignored", nwr, 0);
    chk("R10 stall low when idle", stall_n, 0);
    ch_en[0] = 0; tick(2);

    // R4 channel 3 special with last line clears, R8
    clear_log();
    cfg(3, 2'd3, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 28'h2000000, 28'h5000000, 6'd1);
    enable(3);
    tick(2);
    last_line = 1; disp_start = 1; tick(1); disp_start = 0;
    tick(30);
    last_line = 0;
    chk("R4 channel 3 display start", nwr, 1);
    chk("R8 channel 3 last line clear", {28'd0, clr_seen}, 32'h8);
    ch_en[3] = 0; tick(2);

    // R4 channel 2 fifo request, repeat keeps enable
    clear_log();
    cfg(2, 2'd3, 1'b1, 2'd0, 2'd2, 1'b1, 1'b0, 28'h2000000, 28'h6000000, 6'd1);
    enable(2);
    tick(2);
    fifo_req = 2'b10; tick(1); fifo_req = 0;
    tick(30);
    chk("R4 channel 2 fifo trigger", nwr, 1);
    chk("R8 no clear no irq", {24'd0, clr_seen, irq_seen}, 0);
    ch_en[2] = 0; tick(2);

    // R11 simultaneous: lower channel first
    clear_log();
    cfg(1, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 28'h2000000, 28'h4000000, 6'd1);
    cfg(3, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 28'h2000000, 28'h5000000, 6'd1);
    ch_en[1] = 1; ch_en[3] = 1;
    tick(40);
    chk("R11 lowest channel first", {4'd0, wlog[0]}, 32'h4000000);
    chk("R11 then next channel", {4'd0, wlog[1]}, 32'h5000000);
    ch_en = 0; tick(2);

    // R11 preemption between units
    clear_log();
    cfg(2, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 28'h2000000, 28'h6000000, 6'd6);
    cfg(0, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 28'h2000000, 28'h3000000, 6'd1);
    enable(2);
    tick(10);
    enable(0);
    tick(80);
    idx = -1;
    for (int j = 0; j < 7; j++) if (wlog[j][27:24] == 4'h3) idx = j;
    chk("R11 total writes", nwr, 7);
    chk("R11 preempt mid burst", {31'd0, idx > 0 && idx < 6}, 1);
    ch_en = 0; tick(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule